// File: doc/BRIEF.md
# ISDN Terminal Layer-1 Activation Controller

This block controls layer-1 activation and deactivation on the terminal side of an ISDN S/T interface. The line receiver delivers a decoded class for each received signal and a frame-sync flag. A frame tick marks each received frame. The microprocessor issues four single-cycle commands: activate, clock on, deactivate and analog loop. From these inputs the block chooses the signal type that the line transmitter sends, and it drives an internal loopback control and a clock-enable. It also presents a 4-bit state code that software can read.

The block has three deactivated states:

- deactivated with clocks stopped;
- deactivated with clocks running;
- awaiting deactivation, which is entered after a long quiet spell on the line.

The active path runs through five further states: awaiting signal, identifying input, synchronized, activated and lost framing. Two analog-loop states cover internal self-test. Before the clock-enable rises, a parameterised cycle counter models the oscillator start-up. A quiet-line filter counts frame ticks, and only 64 consecutive INFO 0 frames can tear down an established link.

When several commands arrive in the same cycle, deactivate wins. Analog loop comes next, then activate, then clock on. Any command that applies in the current state takes precedence over the received signal.

Top module: `te_l1_act`

## Requirements
- R1: After reset the state code is 0x0 (deactivated, clocks stopped). tx_info is 2'b00 (INFO 0), loop_en is 0 and clk_en is 0.
- R2: In state 0x0, the clock-on command moves the block to 0x1 (deactivated, clocks running). clk_en rises exactly WAKE_CYCLES clock cycles after the state changes.
- R3: The deactivate command moves the block to 0x0 from every state. clk_en and loop_en are low one cycle later.
- R4: In any of 0x0, 0x1 or 0x2, the activate command moves the block to 0x4 (awaiting signal), where tx_info is 2'b01 (INFO 1). In any other state the activate command has no effect.
- R5: In 0x0, 0x1 or 0x4, a received class other than 2'b00 (INFO 0) moves the block to 0x5 (identifying input), where tx_info is INFO 0.
- R6: In 0x5 or 0x8, rx_sync high with rx_class 2'b10 (INFO 2) moves the block to 0x6, and rx_sync high with rx_class 2'b11 (INFO 4) moves it to 0x7. Under the same sync condition, state 0x6 moves to 0x7 on INFO 4, and state 0x7 moves to 0x6 on INFO 2. In 0x6 and 0x7, tx_info is 2'b11 (INFO 3).
- R7: In 0x6 or 0x7, a low rx_sync moves the block to 0x8 (lost framing), where tx_info is INFO 0.
- R8: In 0x5 to 0x8, the block moves to 0x2 (awaiting deactivation) when rx_class is INFO 0 on FILT_FRAMES consecutive frame ticks. Any cycle with another class restarts the count. Cycles without a frame tick do not advance the count.
- R9: In 0x2, a class other than INFO 0 moves the block to 0x5. The clock-on command moves it to 0x1, and the deactivate command moves it to 0x0.
- R10: In 0x0, 0x1 or 0x2, the analog-loop command moves the block to 0xA with loop_en high and tx_info at INFO 0. rx_sync high in 0xA moves it to 0xB, and rx_sync low in 0xB returns it to 0xA.
- R11: state_code takes the code of a new state exactly one clock cycle after the state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_class | input | 2 | Received class: 00 INFO 0, 01 other non-INFO 0, 10 INFO 2, 11 INFO 4 |
| rx_sync | input | 1 | Receiver frame-synchronized |
| frame_tick | input | 1 | One-cycle pulse per received frame |
| cmd_act | input | 1 | Activate request pulse |
| cmd_clk_on | input | 1 | Clock-on command pulse |
| cmd_deact | input | 1 | Deactivate command pulse |
| cmd_loop | input | 1 | Analog-loop command pulse |
| tx_info | output | 2 | Line signal to send: 00 INFO 0, 01 INFO 1, 11 INFO 3 |
| loop_en | output | 1 | Internal transmitter-to-receiver loopback |
| clk_en | output | 1 | Internal clock enable |
| state_code | output | 4 | Registered state indication |

## Verification
A wrong internal state reaches the ports in two ways. tx_info and loop_en follow the state combinationally, so a wrong state shows on them in the same cycle. state_code follows the state with one register of lag. The bench therefore samples the transmit signal before the code, and a misrouted transition shows at the first sample.

A quiet-line counter that restarts at the wrong moment, or that counts cycles instead of frames, stays invisible until the 64th tick. At that tick the code moves to 0x2 too early or too late, so the bench probes the count on both sides of that boundary. A wrong wake counter shows on clk_en one cycle before or after the expected edge.

// File: rtl/te_l1_act.sv
module te_l1_act #(
  parameter int FILT_FRAMES = 64,
  parameter int WAKE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rx_class,
  input  logic       rx_sync,
  input  logic       frame_tick,
  input  logic       cmd_act,
  input  logic       cmd_clk_on,
  input  logic       cmd_deact,
  input  logic       cmd_loop,
  output logic [1:0] tx_info,
  output logic       loop_en,
  output logic       clk_en,
  output logic [3:0] state_code
);
  localparam int FW = $clog2(FILT_FRAMES + 1);
  localparam int WW = $clog2(WAKE_CYCLES + 1);

  localparam logic [3:0] S_OFF = 4'h0, S_CLK = 4'h1, S_AWD = 4'h2, S_F4 = 4'h4,
                         S_F5 = 4'h5, S_F6 = 4'h6, S_F7 = 4'h7, S_F8 = 4'h8,
                         S_LPI = 4'hA, S_LPA = 4'hB;
  localparam logic [1:0] RX_I0 = 2'b00, RX_I2 = 2'b10, RX_I4 = 2'b11;
  localparam logic [1:0] TX_I0 = 2'b00, TX_I1 = 2'b01, TX_I3 = 2'b11;

  logic [3:0]    state_q, state_d;
  logic [FW-1:0] filt_q;
  logic [WW-1:0] wake_q;
  logic          clk_en_q;

  wire rx_idle  = (rx_class == RX_I0);
  wire in_f3    = (state_q == S_OFF) || (state_q == S_CLK) || (state_q == S_AWD);
  wire filt_st  = (state_q == S_F5) || (state_q == S_F6) || (state_q == S_F7) || (state_q == S_F8);
  wire got_i2   = rx_sync && (rx_class == RX_I2);
  wire got_i4   = rx_sync && (rx_class == RX_I4);
  wire filt_hit = filt_st && rx_idle && frame_tick && (filt_q == FW'(FILT_FRAMES - 1));

  always_comb begin
    state_d = state_q;
    if (cmd_deact) begin
      state_d = S_OFF;
    end else begin
      case (state_q)
        S_OFF, S_CLK, S_AWD: begin
          if (cmd_loop)        state_d = S_LPI;
          else if (cmd_act)    state_d = S_F4;
          else if (cmd_clk_on) state_d = S_CLK;
          else if (!rx_idle)   state_d = S_F5;
        end
        S_F4: if (!rx_idle) state_d = S_F5;
        S_F5: begin
          if (filt_hit)    state_d = S_AWD;
          else if (got_i2) state_d = S_F6;
          else if (got_i4) state_d = S_F7;
        end
        S_F6: begin
          if (filt_hit)     state_d = S_AWD;
          else if (!rx_sync) state_d = S_F8;
          else if (got_i4)  state_d = S_F7;
        end
        S_F7: begin
          if (filt_hit)     state_d = S_AWD;
          else if (!rx_sync) state_d = S_F8;
          else if (got_i2)  state_d = S_F6;
        end
        S_F8: begin
          if (filt_hit)    state_d = S_AWD;
          else if (got_i2) state_d = S_F6;
          else if (got_i4) state_d = S_F7;
        end
        S_LPI: if (rx_sync)  state_d = S_LPA;
        S_LPA: if (!rx_sync) state_d = S_LPI;
        default: state_d = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_OFF;
      state_code <= S_OFF;
    end else begin
      state_q    <= state_d;
      state_code <= state_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !filt_st || !rx_idle || filt_hit) filt_q <= '0;
    else if (frame_tick) filt_q <= filt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || state_q == S_OFF) begin
      wake_q   <= '0;
      clk_en_q <= 1'b0;
    end else if (!clk_en_q) begin
      if (wake_q == WW'(WAKE_CYCLES - 1)) clk_en_q <= 1'b1;
      else wake_q <= wake_q + 1'b1;
    end
  end

  always_comb begin
    case (state_q)
      S_F4:       tx_info = TX_I1;
      S_F6, S_F7: tx_info = TX_I3;
      default:    tx_info = TX_I0;
    endcase
  end

  assign loop_en = (state_q == S_LPI) || (state_q == S_LPA);
  assign clk_en  = clk_en_q;

  logic unused_ok;
  assign unused_ok = in_f3;
endmodule

// File: rtl/te_l1_act_chk.sv
module te_l1_act_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] rx_class,
  input logic       frame_tick,
  input logic [3:0] state_q,
  input logic [3:0] state_code,
  input logic [1:0] tx_info,
  input logic       loop_en,
  input logic       clk_en
);
  AST_CODE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != $past(state_q)) |=> (state_code != $past(state_code))); // R11
  AST_INFO1_MEANS_F4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_info == 2'b01) |=> (state_code == 4'h4)); // R4
  AST_LOOP_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (tx_info == 2'b00)); // R10
  AST_NOCLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 4'h0 && $past(state_q) == 4'h0) |-> !clk_en); // R3
  AST_WAKE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> ($past(state_q) != 4'h0)); // R2
  AST_FILTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 4'h2 && $past(state_q) != 4'h2) |-> ($past(frame_tick) && $past(rx_class) == 2'b00)); // R8
endmodule

bind te_l1_act te_l1_act_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_class(rx_class), .frame_tick(frame_tick),
  .state_q(state_q), .state_code(state_code), .tx_info(tx_info),
  .loop_en(loop_en), .clk_en(clk_en)
);

// File: tb/te_l1_act_bench.sv
`timescale 1ns/1ps
module te_l1_act_bench;
  localparam int WAKE = 6;
  localparam int FILT = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] rx_class = 2'b00;
  logic rx_sync = 1'b0, frame_tick = 1'b0;
  logic cmd_act = 1'b0, cmd_clk_on = 1'b0, cmd_deact = 1'b0, cmd_loop = 1'b0;
  logic [1:0] tx_info;
  logic loop_en, clk_en;
  logic [3:0] state_code;
  int errs = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  te_l1_act #(.FILT_FRAMES(FILT), .WAKE_CYCLES(WAKE)) u_te_l1_act (
    .clk(clk), .rst_n(rst_n), .rx_class(rx_class), .rx_sync(rx_sync),
    .frame_tick(frame_tick), .cmd_act(cmd_act), .cmd_clk_on(cmd_clk_on),
    .cmd_deact(cmd_deact), .cmd_loop(cmd_loop), .tx_info(tx_info),
    .loop_en(loop_en), .clk_en(clk_en), .state_code(state_code));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input int k);
    case (k)
      0: cmd_act = 1'b1;
      1: cmd_clk_on = 1'b1;
      2: cmd_deact = 1'b1;
      default: cmd_loop = 1'b1;
    endcase
    @(negedge clk);
    cmd_act = 1'b0; cmd_clk_on = 1'b0; cmd_deact = 1'b0; cmd_loop = 1'b0;
  endtask

  task automatic rx_go(input logic [1:0] c, input logic s);
    rx_class = c; rx_sync = s;
    repeat (2) @(negedge clk);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 code", state_code, 8'h0);
    chk("R1 tx", tx_info, 8'h0);
    chk("R1 loop", loop_en, 8'h0);
    chk("R1 clk_en", clk_en, 8'h0);
  endtask

  task automatic t_clock;
    cmd(1);
    repeat (WAKE - 1) @(negedge clk);
    chk("R2 code", state_code, 8'h1);
    chk("R2 clk_en early", clk_en, 8'h0);
    @(negedge clk);
    chk("R2 clk_en on time", clk_en, 8'h1);
    cmd(2);
    @(negedge clk);
    chk("R3 code", state_code, 8'h0);
    chk("R3 clk_en", clk_en, 8'h0);
  endtask

  task automatic t_activate;
    cmd(0);
    chk("R4 tx INFO1", tx_info, 8'h1);
    chk("R11 code lags", state_code, 8'h0);
    @(negedge clk);
    chk("R4 code", state_code, 8'h4);
    rx_go(2'b01, 1'b0);
    chk("R5 code", state_code, 8'h5);
    chk("R5 tx", tx_info, 8'h0);
    rx_go(2'b10, 1'b1);
    chk("R6 INFO2 code", state_code, 8'h6);
    chk("R6 tx INFO3", tx_info, 8'h3);
    rx_go(2'b11, 1'b1);
    chk("R6 INFO4 code", state_code, 8'h7);
    chk("R6 tx F7", tx_info, 8'h3);
    cmd(0);
    @(negedge clk);
    chk("R4 ignored in F7", state_code, 8'h7);
    chk("R4 ignored tx", tx_info, 8'h3);
    rx_go(2'b11, 1'b0);
    chk("R7 code", state_code, 8'h8);
    chk("R7 tx", tx_info, 8'h0);
    rx_go(2'b10, 1'b1);
    chk("R6 resync code", state_code, 8'h6);
    rx_go(2'b11, 1'b1);
    chk("R6 F6 to F7", state_code, 8'h7);
  endtask

  task automatic t_filter;
    rx_go(2'b00, 1'b0);
    chk("R7 lost to F8", state_code, 8'h8);
    repeat (300) @(negedge clk);
    chk("R8 no tick no count", state_code, 8'h8);
    frames(40);
    rx_go(2'b01, 1'b0);
    rx_go(2'b00, 1'b0);
    frames(FILT - 1);
    chk("R8 restart after noise", state_code, 8'h8);
    frames(1);
    chk("R8 filter expiry", state_code, 8'h2);
    rx_go(2'b01, 1'b0);
    chk("R9 signal to F5", state_code, 8'h5);
    rx_go(2'b00, 1'b0);
    frames(FILT);
    chk("R8 filter from F5", state_code, 8'h2);
    cmd(1);
    @(negedge clk);
    chk("R9 clk cmd", state_code, 8'h1);
    rx_go(2'b01, 1'b0);
    chk("R5 from clocked F3", state_code, 8'h5);
    rx_go(2'b00, 1'b0);
    frames(FILT);
    chk("R8 again", state_code, 8'h2);
    cmd(2);
    @(negedge clk);
    chk("R9 deact cmd", state_code, 8'h0);
  endtask

  task automatic t_loop;
    cmd(3);
    chk("R10 loop_en", loop_en, 8'h1);
    chk("R10 tx quiet", tx_info, 8'h0);
    @(negedge clk);
    chk("R10 init code", state_code, 8'hA);
    rx_go(2'b00, 1'b1);
    chk("R10 active code", state_code, 8'hB);
    rx_go(2'b00, 1'b0);
    chk("R10 sync loss", state_code, 8'hA);
    cmd(2);
    @(negedge clk);
    chk("R3 loop exit code", state_code, 8'h0);
    chk("R3 loop_en low", loop_en, 8'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_clock();
    t_activate();
    t_filter();
    t_loop();
    finish_run();
  end
endmodule